// File: doc/BRIEF.md
# Watchdog Protection Control Register

This block is the 8-bit control and status register that sits in front of a watchdog timer. Its purpose is to make it hard for a runaway program to change the watchdog by accident. It holds a small set of stored bits and answers a simple CPU register bus, which has a write strobe, write data and combinational read data. On every bus write it applies a chain of protection rules.

Two bit positions act as one-shot keys. They are never stored and always read back as 1. A protected bit accepts new data only when its key is written as 0 in the same bus cycle. Two other stored bits are enables:

- Bit 6 opens bus writes to the external watchdog counter register. It is driven out as `cnt_wr_en`.
- Bit 4 opens writes to bits 2 and 0.

The gating by bit 4 always uses its value from before the current write. Unlocking the register therefore takes two bus writes.

The block does not count, detect overflow or generate a reset. It gives no meaning to bits 2 and 0 beyond storing them under protection.

Top module: `wdg_prot_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, all stored bits (6, 4, 2, 0) are cleared. After that edge, `rd_data` reads 8'h28 and `cnt_wr_en` is 0.
- R2: Bit 6 takes `wr_data[6]` on every clock edge with `wr_stb` high, and it needs no key. `cnt_wr_en` always equals stored bit 6 and `rd_data[6]`.
- R3: Bit 4 takes `wr_data[4]` on a write only when `wr_data[5]` is 0 in that same write. Otherwise it keeps its value.
- R4: Bits 5 and 3 of `rd_data` always read 1, whatever was written to them.
- R5: Bit 2 takes `wr_data[2]` on a write only when `wr_data[3]` is 0 and stored bit 4 was 1 before that write. Otherwise it keeps its value.
- R6: Bit 0 takes `wr_data[0]` on a write only when stored bit 4 was 1 before that write. Otherwise it keeps its value.
- R7: Bits 7 and 1 of `rd_data` always read 0 and ignore writes.
- R8: When `wr_stb` is low, no stored bit changes.
- R9: A write that sets bit 4 does not open bits 2 and 0 in that same write. Bits 2 and 0 can change only on a later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Bus write strobe, sampled on the rising edge |
| wr_data | input | 8 | Bus write data, holding the keys and the new bit values |
| rd_data | output | 8 | Combinational read value of the register |
| cnt_wr_en | output | 1 | Enable for bus writes to the external watchdog counter register (stored bit 6) |

## Verification
Every stored bit of this register is visible at `rd_data`, and bit 6 is also visible on `cnt_wr_en`. A wrong internal value therefore shows at the ports one clock after the write that caused it. The harder faults stay hidden until the enable chain is walked. Examples are a key that gates the wrong bit, a gate that uses the newly written bit 4 instead of its earlier value, or a key that gets stored. Such faults show only when a write hits a lock in a particular state. For that reason, every cycle is checked against a behavioural model under both scripted unlock sequences and random traffic.

// File: rtl/wdg_prot_pkg.sv
package wdg_prot_pkg;

    localparam int CTL_W = 8;

    // Bit positions visible on the bus.
    localparam int POS_CNT_WE  = 6;
    localparam int POS_KEY_REG = 5;
    localparam int POS_REG_WE  = 4;
    localparam int POS_KEY_G2  = 3;
    localparam int POS_G2      = 2;
    localparam int POS_G0      = 0;

    // Stored field indices.
    localparam int NFLD    = 4;
    localparam int FLD_G0  = 0;
    localparam int FLD_G2  = 1;
    localparam int FLD_REG = 2;
    localparam int FLD_CNT = 3;

    typedef logic [CTL_W-1:0] ctl_word_t;
    typedef logic [NFLD-1:0]  fld_vec_t;

    typedef struct packed {
        logic stb;
        ctl_word_t data;
    } bus_wr_t;

    typedef struct packed {
        fld_vec_t en;
        fld_vec_t val;
    } fld_upd_t;

    function automatic int fld_pos(input int f);
        case (f)
            FLD_CNT: return POS_CNT_WE;
            FLD_REG: return POS_REG_WE;
            FLD_G2:  return POS_G2;
            default: return POS_G0;
        endcase
    endfunction

    function automatic ctl_word_t build_read(input fld_vec_t q);
        ctl_word_t w;
        w = '0;
        for (int f = 0; f < NFLD; f++) begin
            w[fld_pos(f)] = q[f];
        end
        w[POS_KEY_REG] = 1'b1;
        w[POS_KEY_G2]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
    import wdg_prot_pkg::*;
(
    input  bus_wr_t  bus,
    input  logic     reg_we_q,
    output fld_upd_t upd
);
    logic key_reg_open;
    logic key_g2_open;

    always_comb begin
        key_reg_open = ~bus.data[POS_KEY_REG];
        key_g2_open  = ~bus.data[POS_KEY_G2];
    end

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        logic open_f;
        if (f == FLD_CNT) begin : g_cnt
            assign open_f = 1'b1;
        end else if (f == FLD_REG) begin : g_reg
            assign open_f = key_reg_open;
        end else if (f == FLD_G2) begin : g_g2
            assign open_f = key_g2_open & reg_we_q;
        end else begin : g_g0
            assign open_f = reg_we_q;
        end
        assign upd.en[f]  = bus.stb & open_f;
        assign upd.val[f] = bus.data[fld_pos(f)];
    end
endmodule

// File: rtl/wdg_ctl_store.sv
module wdg_ctl_store
    import wdg_prot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_wr_t  bus,
    input  fld_upd_t upd,
    output fld_vec_t fld_q
);
    for (genvar f = 0; f < NFLD; f++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q[f] <= 1'b0;
            end else if (upd.en[f]) begin
                fld_q[f] <= upd.val[f];
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (fld_q == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus.stb |=> $stable(fld_q)); // R8

    AST_CNT_DIRECT: assert property (@(posedge clk) disable iff (rst)
        bus.stb |=> fld_q[FLD_CNT] == $past(bus.data[POS_CNT_WE])); // R2

    AST_REG_KEYED: assert property (@(posedge clk) disable iff (rst)
        (bus.stb && bus.data[POS_KEY_REG]) |=> $stable(fld_q[FLD_REG])); // R3

    AST_G2_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (bus.stb && (bus.data[POS_KEY_G2] || !fld_q[FLD_REG]))
            |=> $stable(fld_q[FLD_G2])); // R5

    AST_G0_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (bus.stb && !fld_q[FLD_REG]) |=> $stable(fld_q[FLD_G0])); // R6 R9
endmodule

// File: rtl/wdg_read_mux.sv
module wdg_read_mux
    import wdg_prot_pkg::*;
(
    input  fld_vec_t  fld_q,
    output ctl_word_t rd_word
);
    always_comb begin
        rd_word = build_read(fld_q);
    end
endmodule

// File: rtl/wdg_prot_ctl.sv
module wdg_prot_ctl
    import wdg_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output logic             cnt_wr_en
);
    bus_wr_t  bus;
    fld_upd_t upd;
    fld_vec_t fld_q;

    always_comb begin
        bus.stb  = wr_stb;
        bus.data = wr_data;
    end

    wdg_key_gate u_gate (
        .bus      (bus),
        .reg_we_q (fld_q[FLD_REG]),
        .upd      (upd)
    );

    wdg_ctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .bus   (bus),
        .upd   (upd),
        .fld_q (fld_q)
    );

    wdg_read_mux u_rd (
        .fld_q   (fld_q),
        .rd_word (rd_data)
    );

    assign cnt_wr_en = fld_q[FLD_CNT];

    AST_CNT_PORT_MATCH: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_en == rd_data[POS_CNT_WE]); // R2
endmodule

// File: tb/test_wdg_prot_ctl.sv
module test_wdg_prot_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cnt_wr_en;

    int checks = 0;
    int errors = 0;
    int m6 = 0, m4 = 0, m2 = 0, m0 = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdg_prot_ctl i_wdg_prot_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cnt_wr_en (cnt_wr_en)
    );

    function automatic logic [7:0] model_rd();
        return 8'((m6 << 6) | 32 | (m4 << 4) | 8 | (m2 << 2) | m0);
    endfunction

    task automatic compare(input string tag);
        logic [7:0] exp;
        exp = model_rd();
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, exp);
        end
        checks++;
        if (cnt_wr_en !== 1'(m6)) begin
            errors++;
            $display("FAIL %s cnt_wr_en actual %0b expected %0d", tag, cnt_wr_en, m6);
        end
    endtask

    // One clock: apply inputs, advance the model, compare just after the edge.
    task automatic cycle(input bit r, input bit s, input logic [7:0] d, input string tag);
        int n6, n4, n2, n0;
        rst = r; wr_stb = s; wr_data = d;
        n6 = m6; n4 = m4; n2 = m2; n0 = m0;
        if (r) begin
            n6 = 0; n4 = 0; n2 = 0; n0 = 0;
        end else if (s) begin
            n6 = d[6];
            if (d[5] == 1'b0) n4 = d[4];
            if (d[3] == 1'b0 && m4 == 1) n2 = d[2];
            if (m4 == 1) n0 = d[0];
        end
        @(posedge clk);
        #1;
        m6 = n6; m4 = n4; m2 = n2; m0 = n0;
        compare(tag);
    endtask

    initial begin
        #1;
        cycle(1, 0, 8'h00, "R1 reset");
        cycle(1, 1, 8'hFF, "R1 reset beats write");
        checks++;
        if (rd_data !== 8'h28) begin
            errors++;
            $display("FAIL R1 reset value actual %02h expected 28", rd_data);
        end
        cycle(0, 1, 8'hFF, "R3 R4 R7 keys set, all locked");
        cycle(0, 0, 8'h00, "R8 idle");
        cycle(0, 1, 8'h15, "R9 reg enable set, same-write guards blocked");
        cycle(0, 1, 8'h13, "R5 R6 guards open after enable");
        cycle(0, 1, 8'h1A, "R5 key b3 high keeps bit2, R7 bit1 ignored");
        cycle(0, 1, 8'h50, "R2 R3 counter enable on, bit0 cleared");
        cycle(0, 0, 8'hFF, "R8 strobe low ignores data");
        cycle(0, 1, 8'h20, "R3 key high keeps bit4, R2 bit6 off");
        cycle(0, 1, 8'h84, "R3 R7 clear reg enable, bit7 ignored");
        cycle(0, 1, 8'h05, "R5 R6 locked after disable");
        cycle(0, 1, 8'h40, "R2 counter enable on");
        cycle(1, 0, 8'h00, "R1 mid-run reset");
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (i % 5 == 0) d[5] = 1'b0;
            if (i % 3 == 0) d[3] = 1'b0;
            cycle(0, ($urandom % 4) != 0, d, "R2 R3 R5 R6 R8 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule